// File: doc/BRIEF.md
# Scanning ADC Sequencer

This block drives a multi-channel successive-approximation converter through a programmable scan list. Up to eight list slots each name one of eight analog inputs; the sequencer walks the slots from slot 0 up to a programmed last slot. For each slot it requests a conversion and waits for the converter's done strobe. It then writes the 12-bit result, tagged with the channel number, into a result FIFO.

A scan runs either once or periodically. In periodic mode a tick timer separates passes, using a programmable tick length and a programmable number of ticks. Software reads results through a first-word-fall-through pop port. An interrupt output is raised while the FIFO fill level is at or above a programmable threshold, provided the interrupt is enabled. A full FIFO drops new results and sets a sticky overflow flag.

Register map (word address on `reg_addr`):
- 0, control/status: bit 0 start (write 1), bit 1 continuous enable, bit 2 stop (write 1), bit 3 interrupt enable, bit 4 FIFO flush (write 1), bits 13:8 fill threshold, bit 16 busy (read), bit 17 overflow (read, write 1 clears), bits 29:24 fill count (read).
- 1, scan list: bits 26:24 last slot index, slot n channel in bits 3n+2:3n.
- 2, timing: bits 2:0 tick-length select, bits 15:8 ticks per period.

Top module: `scan_adc_seq`

## Requirements
- R1: After reset the sequencer is idle, busy and overflow read 0, the FIFO is empty, the interrupt is low, and the timing register reads ticks per period 1 with tick select 0.
- R2: A pass converts slots in ascending order from slot 0 to the last index in scan-list bits 26:24, where slot n's channel sits in bits 3n+2:3n. A last index of 0 converts exactly one slot.
- R3: With bit 1 clear, a start runs exactly one pass and then stops. Busy (status bit 16) is high from the cycle after the start write until the last slot's result is written. The conversion request stays high with a stable channel until done is seen.
- R4: With bit 1 set, passes repeat. After the last result of a pass, the request stays low for exactly T*L cycles. T is the ticks per period, with 0 treated as 1. L is TICK_BASE shifted left by the tick select.
- R5: Writing 1 to bit 2 returns the sequencer to idle on the next edge, clears the continuous-enable bit, and stops further conversions.
- R6: Each FIFO entry holds the low 12 bits of the converter data and the 3-bit channel. Entries leave in arrival order, and a pop on an empty FIFO has no effect.
- R7: A result that arrives while the FIFO holds FIFO_DEPTH entries is dropped and sets the sticky overflow bit 17, which only a write of 1 to bit 17 clears.
- R8: The interrupt is high exactly when interrupt enable (bit 3) is set and the fill count is at or above the threshold in bits 13:8.
- R9: Writing 1 to bit 4 empties the FIFO on the next edge.
- R10: A start written while a pass is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| conv_req | output | 1 | Conversion request, held until done |
| conv_chan | output | 3 | Channel to convert |
| conv_done | input | 1 | Conversion complete strobe |
| conv_data | input | CONV_W | Raw converter result |
| pop | input | 1 | Remove the head FIFO entry |
| pop_valid | output | 1 | FIFO not empty |
| pop_value | output | 12 | Head entry sample value |
| pop_chan | output | 3 | Head entry channel number |
| irq | output | 1 | Fill-threshold interrupt |

## Verification
The assertions assume that the converter raises done only while a request is pending, for a single cycle per conversion. They also assume that converter data above bit 11 may hold anything. The bench's converter model answers a fixed number of cycles after each request with a one-cycle done pulse. It deliberately sets the upper data bits, so the masking path is exercised without breaking that contract. Pops are issued only while no scan is running, so the FIFO never sees a pop and a push competing for the last free place.

// File: rtl/scanseq_pkg.sv
`timescale 1ns/1ps
package scanseq_pkg;
    localparam int CHAN_W    = 3;
    localparam int NUM_SLOTS = 8;
    localparam int SLOT_W    = $clog2(NUM_SLOTS);
    localparam int LIST_W    = NUM_SLOTS * CHAN_W;
    localparam int SAMPLE_W  = 12;
    localparam int TICKS_W   = 8;
    localparam int DLY_W     = 3;

    // control/status word bit positions
    localparam int CB_START  = 0;
    localparam int CB_CONT   = 1;
    localparam int CB_STOP   = 2;
    localparam int CB_IRQEN  = 3;
    localparam int CB_FLUSH  = 4;
    localparam int CB_THR    = 8;
    localparam int CB_BUSY   = 16;
    localparam int CB_OVF    = 17;
    localparam int CB_COUNT  = 24;
    // scan list and timing fields
    localparam int LB_LAST   = 24;
    localparam int TB_DLY    = 0;
    localparam int TB_TICKS  = 8;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_LIST = 2'd1;
    localparam logic [1:0] A_TIME = 2'd2;

    typedef struct packed {
        logic [CHAN_W-1:0]   chan;
        logic [SAMPLE_W-1:0] value;
    } sample_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CONV = 2'd1,
        ST_GAP  = 2'd2
    } seq_state_e;

    function automatic logic [CHAN_W-1:0] slot_chan(
        input logic [LIST_W-1:0] list,
        input logic [SLOT_W-1:0] idx
    );
        return list[idx*CHAN_W +: CHAN_W];
    endfunction

    function automatic logic [TICKS_W-1:0] ticks_eff(input logic [TICKS_W-1:0] t);
        return (t == '0) ? TICKS_W'(1) : t;
    endfunction
endpackage

// File: rtl/scan_ctrl.sv
`timescale 1ns/1ps
module scan_ctrl
    import scanseq_pkg::*;
#(
    parameter int CONV_W     = 16,
    parameter int TICK_BASE  = 2,
    parameter int TICK_CNT_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic                stop_i,
    input  logic                cont_i,
    input  logic [SLOT_W-1:0]   last_idx_i,
    input  logic [LIST_W-1:0]   list_i,
    input  logic [DLY_W-1:0]    dly_sel_i,
    input  logic [TICKS_W-1:0]  ticks_i,
    output logic                conv_req_o,
    output logic [CHAN_W-1:0]   conv_chan_o,
    input  logic                conv_done_i,
    input  logic [CONV_W-1:0]   conv_data_i,
    output logic                push_o,
    output sample_t             push_data_o,
    output logic                busy_o
);
    seq_state_e              state_q;
    logic [SLOT_W-1:0]       slot_q;
    logic [TICK_CNT_W-1:0]   cyc_q;
    logic [TICKS_W-1:0]      tick_q;
    logic [TICK_CNT_W-1:0]   tick_len;
    logic                    last_slot;
    logic                    unused_conv_hi;

    assign tick_len    = TICK_CNT_W'(TICK_BASE) << dly_sel_i;
    assign last_slot   = (slot_q == last_idx_i);
    assign conv_req_o  = (state_q == ST_CONV);
    assign busy_o      = (state_q == ST_CONV);
    assign conv_chan_o = slot_chan(list_i, slot_q);
    assign push_o      = conv_req_o && conv_done_i;
    assign unused_conv_hi = ^conv_data_i;

    always_comb begin
        push_data_o.chan  = conv_chan_o;
        push_data_o.value = conv_data_i[SAMPLE_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            slot_q  <= '0;
            cyc_q   <= '0;
            tick_q  <= '0;
        end else if (stop_i) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q <= ST_CONV;
                        slot_q  <= '0;
                    end
                end
                ST_CONV: begin
                    if (conv_done_i) begin
                        if (last_slot) begin
                            if (cont_i) begin
                                state_q <= ST_GAP;
                                cyc_q   <= '0;
                                tick_q  <= '0;
                            end else begin
                                state_q <= ST_IDLE;
                            end
                        end else begin
                            slot_q <= slot_q + 1'b1;
                        end
                    end
                end
                ST_GAP: begin
                    if (cyc_q == tick_len - 1'b1) begin
                        cyc_q <= '0;
                        if (tick_q + 1'b1 >= ticks_eff(ticks_i)) begin
                            state_q <= ST_CONV;
                            slot_q  <= '0;
                        end else begin
                            tick_q <= tick_q + 1'b1;
                        end
                    end else begin
                        cyc_q <= cyc_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (conv_req_o && !conv_done_i && !stop_i) |=> (conv_req_o && $stable(conv_chan_o))); // R3
    AST_NEXT_SLOT: assert property (@(posedge clk) disable iff (rst)
        (push_o && !last_slot && !stop_i) |=> conv_req_o); // R2
    AST_SINGLE_END: assert property (@(posedge clk) disable iff (rst)
        (push_o && last_slot && !cont_i) |=> !busy_o); // R3
    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (rst)
        stop_i |=> !conv_req_o); // R5
endmodule

// File: rtl/result_fifo.sv
`timescale 1ns/1ps
module result_fifo
    import scanseq_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush_i,
    input  logic             push_i,
    input  sample_t          push_data_i,
    input  logic             pop_i,
    output sample_t          head_o,
    output logic             valid_o,
    output logic [CNT_W-1:0] count_o,
    input  logic             ovf_clr_i,
    output logic             ovf_o
);
    sample_t          mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count_q;
    logic             full, do_pop, do_push, drop;

    assign full    = (count_q == CNT_W'(DEPTH));
    assign do_pop  = pop_i && (count_q != '0);
    assign do_push = push_i && (!full || do_pop);
    assign drop    = push_i && !do_push;
    assign head_o  = mem[rd_ptr];
    assign valid_o = (count_q != '0);
    assign count_o = count_q;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!flush_i && do_push) mem[wr_ptr] <= push_data_i;
    end

    always_ff @(posedge clk) begin
        if (rst || flush_i) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count_q <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                   ovf_o <= 1'b0;
        else if (drop && !flush_i) ovf_o <= 1'b1;
        else if (ovf_clr_i)        ovf_o <= 1'b0;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        count_q <= CNT_W'(DEPTH)); // R7
    AST_DROP_STICKY: assert property (@(posedge clk) disable iff (rst)
        (push_i && full && !pop_i && !flush_i) |=> ovf_o); // R7
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
        flush_i |=> (count_q == '0)); // R9
    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
        (pop_i && count_q == '0 && !push_i && !flush_i) |=> (count_q == '0)); // R6
endmodule

// File: rtl/scan_adc_seq.sv
`timescale 1ns/1ps
module scan_adc_seq
    import scanseq_pkg::*;
#(
    parameter int FIFO_DEPTH = 32,
    parameter int CONV_W     = 16,
    parameter int TICK_BASE  = 2,
    parameter int TICK_CNT_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_wr,
    input  logic [1:0]          reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    output logic                conv_req,
    output logic [CHAN_W-1:0]   conv_chan,
    input  logic                conv_done,
    input  logic [CONV_W-1:0]   conv_data,
    input  logic                pop,
    output logic                pop_valid,
    output logic [SAMPLE_W-1:0] pop_value,
    output logic [CHAN_W-1:0]   pop_chan,
    output logic                irq
);
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

    logic                cont_q, irq_en_q;
    logic [CNT_W-1:0]    thr_q;
    logic [SLOT_W-1:0]   last_q;
    logic [LIST_W-1:0]   list_q;
    logic [DLY_W-1:0]    dly_q;
    logic [TICKS_W-1:0]  ticks_q;
    logic                ctrl_wr, start, stop, flush, ovf_clr;
    logic                push, busy, ovf;
    sample_t             push_data, head;
    logic [CNT_W-1:0]    count;
    logic                unused_wdata;

    assign ctrl_wr = reg_wr && (reg_addr == A_CTRL);
    assign start   = ctrl_wr && reg_wdata[CB_START];
    assign stop    = ctrl_wr && reg_wdata[CB_STOP];
    assign flush   = ctrl_wr && reg_wdata[CB_FLUSH];
    assign ovf_clr = ctrl_wr && reg_wdata[CB_OVF];
    assign unused_wdata = ^reg_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            cont_q   <= 1'b0;
            irq_en_q <= 1'b0;
            thr_q    <= '0;
            last_q   <= '0;
            list_q   <= '0;
            dly_q    <= '0;
            ticks_q  <= TICKS_W'(1);
        end else if (reg_wr) begin
            case (reg_addr)
                A_CTRL: begin
                    cont_q   <= reg_wdata[CB_CONT] && !reg_wdata[CB_STOP];
                    irq_en_q <= reg_wdata[CB_IRQEN];
                    thr_q    <= reg_wdata[CB_THR +: CNT_W];
                end
                A_LIST: begin
                    list_q <= reg_wdata[LIST_W-1:0];
                    last_q <= reg_wdata[LB_LAST +: SLOT_W];
                end
                A_TIME: begin
                    dly_q   <= reg_wdata[TB_DLY +: DLY_W];
                    ticks_q <= reg_wdata[TB_TICKS +: TICKS_W];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL: begin
                reg_rdata[CB_CONT]           = cont_q;
                reg_rdata[CB_IRQEN]          = irq_en_q;
                reg_rdata[CB_THR +: CNT_W]   = thr_q;
                reg_rdata[CB_BUSY]           = busy;
                reg_rdata[CB_OVF]            = ovf;
                reg_rdata[CB_COUNT +: CNT_W] = count;
            end
            A_LIST: begin
                reg_rdata[LIST_W-1:0]         = list_q;
                reg_rdata[LB_LAST +: SLOT_W]  = last_q;
            end
            A_TIME: begin
                reg_rdata[TB_DLY +: DLY_W]     = dly_q;
                reg_rdata[TB_TICKS +: TICKS_W] = ticks_q;
            end
            default: reg_rdata = '0;
        endcase
    end

    scan_ctrl #(
        .CONV_W(CONV_W), .TICK_BASE(TICK_BASE), .TICK_CNT_W(TICK_CNT_W)
    ) u_ctrl (
        .clk(clk), .rst(rst), .start_i(start), .stop_i(stop), .cont_i(cont_q),
        .last_idx_i(last_q), .list_i(list_q), .dly_sel_i(dly_q), .ticks_i(ticks_q),
        .conv_req_o(conv_req), .conv_chan_o(conv_chan), .conv_done_i(conv_done),
        .conv_data_i(conv_data), .push_o(push), .push_data_o(push_data), .busy_o(busy)
    );

    result_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .flush_i(flush), .push_i(push), .push_data_i(push_data),
        .pop_i(pop), .head_o(head), .valid_o(pop_valid), .count_o(count),
        .ovf_clr_i(ovf_clr), .ovf_o(ovf)
    );

    assign pop_value = head.value;
    assign pop_chan  = head.chan;
    assign irq       = irq_en_q && (count >= thr_q);
endmodule

// File: tb/scan_adc_seq_test.sv
`timescale 1ns/1ps
module scan_adc_seq_test;
    localparam int DEPTH = 32;
    localparam int LAT   = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        conv_req, conv_done = 1'b0;
    logic [2:0]  conv_chan;
    logic [15:0] conv_data = '0;
    logic        pop = 1'b0, pop_valid, irq;
    logic [11:0] pop_value;
    logic [2:0]  pop_chan;

    int n_checks = 0, n_fail = 0, cyc = 0;
    bit done_flag = 0;

    // converter model and result log
    int n_done = 0, n_rise = 0, last_done_cyc = 0, last_gap = 0, wcnt = 0, seq = 0;
    bit prev_req = 0;
    logic [2:0]  mchan [256];
    logic [11:0] mval  [256];
    logic [7:0]  head = 0, tail = 0;
    int mcount = 0;

    scan_adc_seq uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .conv_req(conv_req), .conv_chan(conv_chan),
        .conv_done(conv_done), .conv_data(conv_data), .pop(pop), .pop_valid(pop_valid),
        .pop_value(pop_value), .pop_chan(pop_chan), .irq(irq)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        forever begin
            @(negedge clk);
            if (conv_req && !prev_req) begin
                last_gap = cyc - last_done_cyc;
                n_rise++;
            end
            prev_req = conv_req;
            if (conv_done) begin
                conv_done = 1'b0;
                wcnt = 0;
            end else if (conv_req) begin
                wcnt++;
                if (wcnt >= LAT) begin
                    conv_done = 1'b1;
                    conv_data = {4'hA, 1'b0, conv_chan, seq[7:0]};
                    if (mcount < DEPTH) begin
                        mchan[tail] = conv_chan;
                        mval[tail]  = {1'b0, conv_chan, seq[7:0]};
                        tail++;
                        mcount++;
                    end
                    last_done_cyc = cyc;
                    n_done++;
                    seq++;
                    wcnt = 0;
                end
            end
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
        reg_addr = 2'd0;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            reg_read(2'd0, v);
            if (!v[16]) break;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic flush_all();
        reg_write(2'd0, 32'h10);
        head = tail;
        mcount = 0;
    endtask

    task automatic pop_check(input string tag);
        check(pop_valid === 1'b1, {tag, " valid"}, pop_valid, 1);
        check(pop_chan === mchan[head], {tag, " chan"}, pop_chan, mchan[head]);
        check(pop_value === mval[head], {tag, " value"}, pop_value, mval[head]);
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
        head++;
        mcount--;
    endtask

    task automatic test_reset();
        logic [31:0] v;
        @(negedge clk);
        reg_read(2'd0, v);
        check(v === 32'h0, "R1 ctrl reset", v, 0);
        reg_read(2'd2, v);
        check(v === 32'h100, "R1 timing reset", v, 32'h100);
        check(!irq && !pop_valid && !conv_req, "R1 outputs idle", {irq, pop_valid, conv_req}, 0);
    endtask

    task automatic test_single();
        logic [31:0] v;
        int d0;
        reg_write(2'd1, (32'd2 << 24) | (32'd7 << 6) | (32'd2 << 3) | 32'd5);
        d0 = n_done;
        reg_write(2'd0, 32'h1);
        reg_read(2'd0, v);
        check(v[16] === 1'b1, "R3 busy after start", v[16], 1);
        wait_idle();
        repeat (20) @(negedge clk);
        check(n_done - d0 == 3, "R3 one pass only", n_done - d0, 3);
        check(!conv_req, "R3 request low after pass", conv_req, 0);
        check(pop_chan === 3'd5, "R2 slot0 first", pop_chan, 5);
        pop_check("R2 R6 slot0");
        check(pop_chan === 3'd2, "R2 slot1 second", pop_chan, 2);
        pop_check("R2 R6 slot1");
        check(pop_chan === 3'd7, "R2 slot2 third", pop_chan, 7);
        pop_check("R2 R6 slot2");
        check(!pop_valid, "R6 empty after pops", pop_valid, 0);
        // last index 0: exactly one slot
        reg_write(2'd1, 32'd3);
        d0 = n_done;
        reg_write(2'd0, 32'h1);
        wait_idle();
        repeat (10) @(negedge clk);
        check(n_done - d0 == 1, "R2 last index zero one slot", n_done - d0, 1);
        check(pop_chan === 3'd3, "R2 single slot chan", pop_chan, 3);
        pop_check("R6 single slot");
    endtask

    task automatic test_restart_ignored();
        logic [31:0] v;
        int d0;
        reg_write(2'd1, (32'd1 << 24) | (32'd6 << 3) | 32'd1);
        d0 = n_done;
        reg_write(2'd0, 32'h1);
        reg_write(2'd0, 32'h1);
        wait_idle();
        repeat (20) @(negedge clk);
        check(n_done - d0 == 2, "R10 second start ignored", n_done - d0, 2);
        reg_read(2'd0, v);
        check(v[29:24] == 6'd2, "R10 fifo count", v[29:24], 2);
        flush_all();
    endtask

    task automatic run_periodic(input int sel, input int ticks, input int exp_gap, input string tag);
        logic [31:0] v;
        int r0, d0;
        reg_write(2'd2, (ticks << 8) | sel);
        reg_write(2'd1, 32'd4);
        r0 = n_rise;
        reg_write(2'd0, 32'h3);
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (n_rise >= r0 + 3) break;
        end
        check(last_gap == exp_gap, tag, last_gap, exp_gap);
        reg_write(2'd0, 32'h4);
        reg_read(2'd0, v);
        check(v[1] === 1'b0 && v[16] === 1'b0, "R5 stop clears cont and busy", v[17:0], 0);
        repeat (2) @(negedge clk);
        d0 = n_done;
        repeat (60) @(negedge clk);
        check(n_done == d0 && !conv_req, "R5 no conversions after stop", n_done - d0, 0);
        flush_all();
    endtask

    task automatic test_fill();
        logic [31:0] v;
        logic [31:0] full_list;
        flush_all();
        reg_read(2'd0, v);
        check(v[29:24] == 0 && !pop_valid, "R9 flush empties", v[29:24], 0);
        reg_write(2'd0, 32'h408);           // irq enable, threshold 4
        check(!irq, "R8 irq low when empty", irq, 0);
        reg_write(2'd1, (32'd2 << 24) | 32'o321);
        reg_write(2'd0, 32'h409);
        wait_idle();
        check(!irq, "R8 irq low below threshold", irq, 0);
        reg_write(2'd0, 32'h409);
        wait_idle();
        check(irq, "R8 irq high at threshold", irq, 1);
        reg_write(2'd0, 32'h400);
        check(!irq, "R8 irq masked by enable", irq, 0);
        full_list = 32'd7 << 24;
        for (int s = 0; s < 8; s++) full_list |= s << (3 * s);
        reg_write(2'd1, full_list);
        for (int p = 0; p < 4; p++) begin
            reg_write(2'd0, 32'h401);
            wait_idle();
        end
        reg_read(2'd0, v);
        check(v[29:24] == 6'd32, "R7 count saturates at depth", v[29:24], 32);
        check(v[17] === 1'b1, "R7 overflow sticky set", v[17], 1);
        reg_write(2'd0, 32'h400);
        reg_read(2'd0, v);
        check(v[17] === 1'b1, "R7 overflow kept without clear", v[17], 1);
        reg_write(2'd0, 32'h20400);
        reg_read(2'd0, v);
        check(v[17] === 1'b0, "R7 overflow cleared by write 1", v[17], 0);
        for (int i = 0; i < DEPTH; i++) pop_check("R7 retained order");
        check(!pop_valid, "R6 empty after draining", pop_valid, 0);
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
        reg_read(2'd0, v);
        check(v[29:24] == 0 && !pop_valid, "R6 pop on empty ignored", v[29:24], 0);
        reg_write(2'd1, 32'd1);
        reg_write(2'd0, 32'h1);
        wait_idle();
        reg_read(2'd0, v);
        check(v[29:24] == 1, "R6 count after empty pop", v[29:24], 1);
        pop_check("R6 entry after empty pop");
        reg_write(2'd0, 32'h1);
        wait_idle();
        flush_all();
        @(negedge clk);
        reg_read(2'd0, v);
        check(v[29:24] == 0 && !pop_valid, "R9 flush after pass", v[29:24], 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        test_reset();
        test_single();
        test_restart_ignored();
        run_periodic(1, 3, 13, "R4 gap ticks 3 select 1");
        run_periodic(0, 0, 3, "R4 gap ticks 0 treated as 1");
        test_fill();
        finish_run();
    end
endmodule